// File: doc/BRIEF.md
# Dual-Rate Difference Counter for a Ramp-Compare Column

This block is the digital back end of one column of a ramp-compare converter. It subtracts the reset level from the signal level in the counter itself. During the reset window it counts clocks until the comparator trips. That count is called D1. When the signal window opens, the counter replaces D1 with its two's complement. It then keeps counting through the signal window until the comparator trips again. The carry beyond the top bit is dropped, so the value left in the register is the signal count minus the reset count.

A precomparator flag, sampled when the signal window opens, sets the weight of each signal-window clock. For a small pixel signal, each clock adds one. For a large pixel signal, the clock is steered to bit 1, so each clock adds two and the least significant bit stays as it is. This mode flag is output alongside the code so that downstream logic can decode the code. If a window runs out of clocks before the comparator trips, the result is flagged as overflowed. A synchronous row clear prepares the column for the next row.

Top module: `dcds_col_counter`

## Requirements
- R1: `rst` or `row_clr` drives `code` to 0 and `dbl_mode` and `ovf` to 0 on the next clock, and returns the block to the reset window.
- R2: In the reset window, every clock with `rst_win`=1 and `cmp_trip`=0 adds one to `code`, starting from 0. The first clock with `cmp_trip`=1 stops the count, so that D1 equals the number of such counting clocks.
- R3: Once the comparator has tripped in a window, `code` holds its value. Later values of `cmp_trip` in the same window have no effect.
- R4: The first clock with `sig_win`=1 while in the reset window loads (2^W − D1) mod 2^W into `code`. That clock never counts, and `cmp_trip` is ignored on it.
- R5: With `pre_large`=0 at the load clock, each counting clock in the signal window (`sig_win`=1, `cmp_trip`=0) adds 1. After k counting clocks, `code` = (k − D1) mod 2^W.
- R6: With `pre_large`=1 at the load clock, each counting clock in the signal window adds 2 and bit 0 of `code` is unchanged. After k counting clocks, `code` = (2k − D1) mod 2^W.
- R7: `dbl_mode` equals `pre_large` as sampled on the load clock and holds that value until the next clear. `pre_large` has no effect at any other time.
- R8: In the reset window, a counting clock that arrives after RST_LIMIT counts have already been taken sets `ovf` to 1 instead of counting. `code` then holds RST_LIMIT for the rest of the window.
- R9: In the signal window, a counting clock that arrives after SIG_LIMIT counts have already been taken sets `code` to all ones and `ovf` to 1. Counting then stops.
- R10: `ovf` stays at 1 until `rst` or `row_clr`, including across the change from the reset window to the signal window.
- R11: Clocks on which the open window's enable (`rst_win` or `sig_win`) is 0 neither count nor stop the count. Counting resumes when the enable returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst | input | 1 | Synchronous active-high reset |
| row_clr | input | 1 | Synchronous clear before each row |
| rst_win | input | 1 | Reset-level ramp window enable |
| sig_win | input | 1 | Signal-level ramp window enable; its first high clock performs the complement load |
| cmp_trip | input | 1 | Comparator output, 1 once the ramp has crossed the input |
| pre_large | input | 1 | Precomparator decision, 1 for a large signal (double-weight counting) |
| code | output | W | Difference code (signal count minus reset count, modulo 2^W) |
| dbl_mode | output | 1 | Latched double-weight mode flag |
| ovf | output | 1 | Sticky window-overflow flag |

## Verification
The hardest conditions to reach are the two timeouts. In each, the comparator must stay quiet for exactly the configured number of clocks, and the effect must still be visible at the ports after the window changes. The bench uses a small configuration (6-bit code, short limits). It runs every reset count from zero to the limit against every signal count up to past the signal limit, in both weights, so both saturations and the wrapped negative differences occur naturally. Each long run also contains a pause in the window enable and a flip of the precomparator after the load. This shows that neither the pause nor the late flip changes the result.

// File: rtl/dcds_pkg.sv
package dcds_pkg;

    typedef enum logic {
        PH_RESET  = 1'b0,
        PH_SIGNAL = 1'b1
    } phase_e;

    typedef struct packed {
        logic inc;
        logic load;
        logic sat;
        logic dbl;
    } cnt_ctl_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned bits_for(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/dcds_phase_ctrl.sv
module dcds_phase_ctrl
    import dcds_pkg::*;
#(
    parameter int unsigned RST_LIMIT = 1023,
    parameter int unsigned SIG_LIMIT = 4095
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     row_clr,
    input  logic     rst_win,
    input  logic     sig_win,
    input  logic     cmp_trip,
    input  logic     pre_large,
    output cnt_ctl_t ctl,
    output phase_e   phase,
    output logic     halted,
    output logic     dbl_q,
    output logic     ovf_q
);
    localparam int unsigned TW = bits_for(max_u(RST_LIMIT, SIG_LIMIT));
    localparam logic [TW-1:0] RLIM = TW'(RST_LIMIT);
    localparam logic [TW-1:0] SLIM = TW'(SIG_LIMIT);

    phase_e        phase_q;
    logic          halt_q;
    logic [TW-1:0] tally_q;

    logic          win, xfer, active, tripped, timeout;
    logic [TW-1:0] lim;

    always_comb begin
        win     = (phase_q == PH_RESET) ? rst_win : sig_win;
        lim     = (phase_q == PH_RESET) ? RLIM : SLIM;
        xfer    = (phase_q == PH_RESET) && sig_win;
        active  = !xfer && win && !halt_q;
        tripped = active && cmp_trip;
        timeout = active && !cmp_trip && (tally_q == lim);
        ctl.inc  = active && !cmp_trip && !timeout;
        ctl.load = xfer;
        ctl.sat  = timeout && (phase_q == PH_SIGNAL);
        ctl.dbl  = dbl_q && (phase_q == PH_SIGNAL);
    end

    always_ff @(posedge clk) begin
        if (rst || row_clr) begin
            phase_q <= PH_RESET;
            halt_q  <= 1'b0;
            tally_q <= '0;
            dbl_q   <= 1'b0;
            ovf_q   <= 1'b0;
        end else if (xfer) begin
            phase_q <= PH_SIGNAL;
            halt_q  <= 1'b0;
            tally_q <= '0;
            dbl_q   <= pre_large;
        end else begin
            if (tripped || timeout) halt_q <= 1'b1;
            if (ctl.inc) tally_q <= tally_q + 1'b1;
            if (timeout) ovf_q <= 1'b1;
        end
    end

    assign phase  = phase_q;
    assign halted = halt_q;

endmodule

// File: rtl/dcds_count_core.sv
module dcds_count_core
    import dcds_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         row_clr,
    input  cnt_ctl_t     ctl,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;
    logic         lsb_d;
    logic         carry1;

    // Bit 0 toggles only at single weight; the upper field is clocked
    // either by bit 0 wrapping or directly at double weight.
    always_comb begin
        carry1 = ctl.inc && (ctl.dbl || cnt_q[0]);
        lsb_d  = (ctl.inc && !ctl.dbl) ? ~cnt_q[0] : cnt_q[0];
    end

    generate
        if (W > 1) begin : g_split
            always_comb begin
                cnt_d[0]   = lsb_d;
                cnt_d[W-1:1] = cnt_q[W-1:1] + {{(W-2){1'b0}}, carry1};
            end
        end else begin : g_single
            always_comb cnt_d = lsb_d;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || row_clr) begin
            cnt_q <= '0;
        end else if (ctl.load) begin
            cnt_q <= ~cnt_q + 1'b1;
        end else if (ctl.sat) begin
            cnt_q <= '1;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/dcds_col_counter.sv
module dcds_col_counter
    import dcds_pkg::*;
#(
    parameter int unsigned W         = 12,
    parameter int unsigned RST_LIMIT = 1023,
    parameter int unsigned SIG_LIMIT = 4095
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         row_clr,
    input  logic         rst_win,
    input  logic         sig_win,
    input  logic         cmp_trip,
    input  logic         pre_large,
    output logic [W-1:0] code,
    output logic         dbl_mode,
    output logic         ovf
);
    cnt_ctl_t ctl_w;
    phase_e   phase_w;
    logic     halt_w;

    dcds_phase_ctrl #(
        .RST_LIMIT(RST_LIMIT),
        .SIG_LIMIT(SIG_LIMIT)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .row_clr  (row_clr),
        .rst_win  (rst_win),
        .sig_win  (sig_win),
        .cmp_trip (cmp_trip),
        .pre_large(pre_large),
        .ctl      (ctl_w),
        .phase    (phase_w),
        .halted   (halt_w),
        .dbl_q    (dbl_mode),
        .ovf_q    (ovf)
    );

    dcds_count_core #(
        .W(W)
    ) core_i (
        .clk    (clk),
        .rst    (rst),
        .row_clr(row_clr),
        .ctl    (ctl_w),
        .cnt    (code)
    );

endmodule

// File: rtl/dcds_col_counter_chk.sv
module dcds_col_counter_chk
    import dcds_pkg::*;
#(
    parameter int unsigned W = 12
) (
    input logic         clk,
    input logic         rst,
    input logic         row_clr,
    input logic         sig_win,
    input logic [W-1:0] code,
    input logic         dbl_mode,
    input logic         ovf,
    input phase_e       phase,
    input logic         halted,
    input cnt_ctl_t     ctl
);
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        row_clr |=> (code == '0) && !dbl_mode && !ovf); // R1

    AST_HOLD_AFTER_TRIP: assert property (@(posedge clk) disable iff (rst)
        (halted && phase == PH_SIGNAL && !row_clr) |=> $stable(code)); // R3

    AST_LOAD_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RESET && sig_win && !row_clr) |=> (code == W'(0) - $past(code))); // R4

    AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SIGNAL && ctl.inc && !dbl_mode && !row_clr) |=> (code == $past(code) + W'(1))); // R5

    AST_STEP_DOUBLE: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SIGNAL && ctl.inc && dbl_mode && !row_clr) |=> (code == $past(code) + W'(2))); // R6

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SIGNAL && !row_clr) |=> $stable(dbl_mode)); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf && !row_clr) |=> ovf); // R10

endmodule

bind dcds_col_counter dcds_col_counter_chk #(.W(W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .row_clr (row_clr),
    .sig_win (sig_win),
    .code    (code),
    .dbl_mode(dbl_mode),
    .ovf     (ovf),
    .phase   (phase_w),
    .halted  (halt_w),
    .ctl     (ctl_w)
);

// File: tb/dcds_col_counter_tb.sv
module dcds_col_counter_tb_top;

    localparam int    W         = 6;
    localparam int    RST_LIMIT = 12;
    localparam int    SIG_LIMIT = 20;
    localparam int    MASK      = (1 << W) - 1;
    localparam time   CLK_PERIOD = 10ns;
    localparam int    WATCHDOG  = 150000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         row_clr = 1'b0;
    logic         rst_win = 1'b0;
    logic         sig_win = 1'b0;
    logic         cmp_trip = 1'b0;
    logic         pre_large = 1'b0;
    logic [W-1:0] code;
    logic         dbl_mode;
    logic         ovf;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    dcds_col_counter #(
        .W(W), .RST_LIMIT(RST_LIMIT), .SIG_LIMIT(SIG_LIMIT)
    ) dut_i (
        .clk(clk), .rst(rst), .row_clr(row_clr), .rst_win(rst_win),
        .sig_win(sig_win), .cmp_trip(cmp_trip), .pre_large(pre_large),
        .code(code), .dbl_mode(dbl_mode), .ovf(ovf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= WATCHDOG && !done) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One row: reset count d1 (or timeout), signal count k at weight big.
    task automatic convert(input int d1, input int k, input bit big, input bit rst_to);
        int exp_d1, exp_code, exp_ovf, nr, done_k;
        bit paused;
        row_clr = 1'b1; step(); row_clr = 1'b0;
        chk("R1 code", code, 0);
        chk("R1 flags", {dbl_mode, ovf}, 0);

        nr     = rst_to ? RST_LIMIT + 3 : d1;
        exp_d1 = rst_to ? RST_LIMIT : d1;
        rst_win = 1'b1; cmp_trip = 1'b0;
        step(nr);
        cmp_trip = 1'b1; step();
        cmp_trip = 1'b0; step();
        cmp_trip = 1'b1; step();
        rst_win = 1'b0; cmp_trip = 1'b0; step();
        chk(rst_to ? "R8 reset count" : "R2 R3 reset count", code, exp_d1);
        chk("R8 reset ovf", ovf, rst_to);

        sig_win = 1'b1; pre_large = big; cmp_trip = 1'b1; step();
        pre_large = ~big; cmp_trip = 1'b0;
        chk("R4 complement", code, (64 * 4 - exp_d1) & MASK);
        chk("R7 mode latch", dbl_mode, big);

        done_k = 0; paused = 1'b0;
        while (done_k < k) begin
            if (k >= 4 && done_k == 2 && !paused) begin
                sig_win = 1'b0; step(2); sig_win = 1'b1; paused = 1'b1;
            end
            step(); done_k++;
        end
        cmp_trip = 1'b1; step();
        cmp_trip = 1'b0; step();
        cmp_trip = 1'b1; step();
        sig_win = 1'b0; cmp_trip = 1'b0; pre_large = 1'b0; step();

        if (k > SIG_LIMIT) begin
            exp_code = MASK; exp_ovf = 1;
            chk("R9 saturate", code, exp_code);
        end else begin
            exp_code = ((big ? 2 : 1) * k - exp_d1 + 64 * 4) & MASK;
            exp_ovf  = rst_to;
            if (paused) chk(big ? "R6 R11 double diff" : "R5 R11 single diff", code, exp_code);
            else        chk(big ? "R6 double diff" : "R5 single diff", code, exp_code);
        end
        chk("R9 R10 ovf", ovf, exp_ovf);
        chk("R7 mode held", dbl_mode, big);
    endtask

    initial begin
        step(3);
        chk("R1 reset code", code, 0);
        chk("R1 reset flags", {dbl_mode, ovf}, 0);
        rst = 1'b0;
        step();
        for (int b = 0; b < 2; b++) begin
            for (int d = 0; d <= RST_LIMIT; d++) begin
                for (int k = 0; k <= SIG_LIMIT + 2; k++) begin
                    convert(d, k, b[0], 1'b0);
                end
            end
            convert(0, 7, b[0], 1'b1);
            convert(0, SIG_LIMIT + 5, b[0], 1'b1);
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule